// File: doc/BRIEF.md
# ADC Threshold Crossing Monitor

This block watches three ADC channels for values that leave an allowed window. A programmable interval timer counts a slow tick enable, which is one pulse every 10 ms. After the programmed number of ticks it raises a one-cycle sample request toward the converter. When the converter returns a result strobe, the block does three things on that cycle. It stores a snapshot of the three channel values and of two GPIO levels. It compares each channel against its own low and high limits. It updates a per-channel "outside" flag.

An event is raised only when a channel moves from inside its window to outside it. A channel that stays outside raises nothing further. It must first be sampled back inside before it can fire again. However many channels cross on the same sample, the result is a single event pulse, together with a mask of the channels that crossed. The snapshot registers hold the captured values that go with the event. Events are emitted only while reporting is enabled. The outside flags are tracked at all times, whether reporting is enabled or not.

Top module: `adc_window_monitor`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `sample_req`, `event_pulse`, `event_mask`, `snap_data` and `snap_gpio` are all zero, and every channel is regarded as inside its window.
- R2: `sample_req` is high for exactly the one cycle that follows the clock edge at which the Nth `tick_en` since the previous request (or since reset) is seen. N is the value of `intvl`, and a value of 0 behaves as 1. With one tick per 10 ms, a value of 10 gives a 100 ms period.
- R3: On a clock edge with `adc_valid` high, `snap_data` takes `adc_data` and `snap_gpio` takes `gpio_lvl`. Channel k occupies bits [k*ADC_W +: ADC_W]. `gpio_lvl[0]` is GPIO2 and `gpio_lvl[1]` is GPIO3. Without `adc_valid`, both snapshot outputs hold their values.
- R4: A channel is outside when its value is strictly below its low limit or strictly above its high limit. A value equal to either limit is inside.
- R5: `event_pulse` goes high in the cycle after a valid sample on which at least one channel moves from inside to outside while `report_en` is high. It lasts exactly one cycle per such sample.
- R6: A channel that is sampled outside again, after already being outside, produces no event. After it has been sampled inside, its next move outside produces an event again.
- R7: With `report_en` low, no event is produced, but each channel's inside/outside state is still updated on every valid sample. A channel that went outside while reporting was disabled does not fire when reporting is re-enabled while it stays outside.
- R8: When several channels cross on the same sample, one pulse is produced. `event_mask` bit k is set for each crossing channel k.
- R9: A channel that is already outside at the first valid sample after reset produces an event.
- R10: `event_mask` is all zeros in every cycle in which `event_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | 10 ms time-base enable |
| intvl | input | INTVL_W | Sample interval in ticks; 0 acts as 1 |
| sample_req | output | 1 | One-cycle request to start a conversion |
| adc_valid | input | 1 | Conversion results present on `adc_data` |
| adc_data | input | 3*ADC_W | Three channel results, channel 0 in the low bits |
| gpio_lvl | input | 2 | Levels of GPIO2 (bit 0) and GPIO3 (bit 1) |
| thr_lo | input | 3*ADC_W | Per-channel low limits, packed like `adc_data` |
| thr_hi | input | 3*ADC_W | Per-channel high limits, packed like `adc_data` |
| report_en | input | 1 | Allows events to be emitted |
| event_pulse | output | 1 | One-cycle crossing event |
| event_mask | output | 3 | Channels that crossed on the reported sample |
| snap_data | output | 3*ADC_W | Channel values from the latest valid sample |
| snap_gpio | output | 2 | GPIO levels from the latest valid sample |

## Verification
The hardest situation to reach is a channel whose outside flag changed while reporting was off. The sign that it was handled correctly is that no event appears later. The stimulus disables reporting, pushes one channel out and samples it there once. It then re-enables reporting and samples the same channel outside again, expecting silence. Finally it brings the channel back inside and then outside once more, where exactly one event must appear. A random phase also toggles `report_en` between samples while the limits change, and a cycle-by-cycle reference model tracks every flag.

// File: rtl/adcwin_pkg.sv
// Shared constants and types for the ADC window monitor.
package adcwin_pkg;
    localparam int NUM_CH   = 3;
    localparam int NUM_GPIO = 2;
    typedef logic [NUM_CH-1:0] ch_mask_t;
endpackage

// File: rtl/adcwin_timer.sv
// Interval timer: counts tick enables and issues a one-cycle sample request
// once the programmed number of ticks has been seen.
// Assumes tick_en is a single-cycle enable; an interval value of 0 acts as 1.
module adcwin_timer #(
    parameter int INTVL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic [INTVL_W-1:0] intvl,
    output logic               sample_req
);
    localparam int CW = INTVL_W + 1;

    logic [INTVL_W-1:0] cnt_q;
    logic [CW-1:0]      cnt_inc;
    logic [CW-1:0]      limit;
    logic               wrap;

    // Next count and the wrap decision against the effective limit.
    always_comb begin
        cnt_inc = {1'b0, cnt_q} + CW'(1);
        limit   = (intvl == '0) ? CW'(1) : {1'b0, intvl};
        wrap    = (cnt_inc >= limit);
    end

    // Tick counter and registered request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            sample_req <= 1'b0;
        end else if (tick_en) begin
            sample_req <= wrap;
            cnt_q      <= wrap ? '0 : cnt_inc[INTVL_W-1:0];
        end else begin
            sample_req <= 1'b0;
        end
    end
endmodule

// File: rtl/adcwin_chan.sv
// One channel's window comparator with edge detection.
// Flags a crossing when a valid sample lies outside [lo, hi] and the previous
// valid sample was inside. Assumes lo <= hi for a meaningful window.
module adcwin_chan #(
    parameter int ADC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_vld,
    input  logic [ADC_W-1:0] value,
    input  logic [ADC_W-1:0] lo,
    input  logic [ADC_W-1:0] hi,
    output logic             crossed
);
    logic outside_now;
    logic outside_q;

    // Strict comparison: equality with a limit counts as inside.
    always_comb begin
        outside_now = (value < lo) || (value > hi);
        crossed     = sample_vld && outside_now && !outside_q;
    end

    // Remember the window state of the most recent valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outside_q <= 1'b0;
        end else if (sample_vld) begin
            outside_q <= outside_now;
        end
    end
endmodule

// File: rtl/adcwin_capture.sv
// Snapshot register: stores channel values and GPIO levels on each valid
// sample and holds them until the next one.
module adcwin_capture #(
    parameter int DATA_W = 30,
    parameter int GPIO_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_vld,
    input  logic [DATA_W-1:0] data_in,
    input  logic [GPIO_W-1:0] gpio_in,
    output logic [DATA_W-1:0] data_q,
    output logic [GPIO_W-1:0] gpio_q
);
    // Load on valid samples, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            gpio_q <= '0;
        end else if (sample_vld) begin
            data_q <= data_in;
            gpio_q <= gpio_in;
        end
    end
endmodule

// File: rtl/adc_window_monitor.sv
// ADC threshold crossing monitor: interval timer, per-channel window
// comparators with re-arm, snapshot and a merged single event pulse.
// Assumes adc_valid marks one cycle of results; events need report_en.
module adc_window_monitor
    import adcwin_pkg::*;
#(
    parameter int ADC_W   = 10,
    parameter int INTVL_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_en,
    input  logic [INTVL_W-1:0]       intvl,
    output logic                     sample_req,
    input  logic                     adc_valid,
    input  logic [NUM_CH*ADC_W-1:0]  adc_data,
    input  logic [NUM_GPIO-1:0]      gpio_lvl,
    input  logic [NUM_CH*ADC_W-1:0]  thr_lo,
    input  logic [NUM_CH*ADC_W-1:0]  thr_hi,
    input  logic                     report_en,
    output logic                     event_pulse,
    output logic [NUM_CH-1:0]        event_mask,
    output logic [NUM_CH*ADC_W-1:0]  snap_data,
    output logic [NUM_GPIO-1:0]      snap_gpio
);
    localparam int DATA_W = NUM_CH * ADC_W;

    ch_mask_t cross_vec;

    adcwin_timer #(.INTVL_W(INTVL_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .intvl      (intvl),
        .sample_req (sample_req)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        adcwin_chan #(.ADC_W(ADC_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .sample_vld (adc_valid),
            .value      (adc_data[g*ADC_W +: ADC_W]),
            .lo         (thr_lo[g*ADC_W +: ADC_W]),
            .hi         (thr_hi[g*ADC_W +: ADC_W]),
            .crossed    (cross_vec[g])
        );
    end

    adcwin_capture #(.DATA_W(DATA_W), .GPIO_W(NUM_GPIO)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_vld (adc_valid),
        .data_in    (adc_data),
        .gpio_in    (gpio_lvl),
        .data_q     (snap_data),
        .gpio_q     (snap_gpio)
    );

    // Merge channel crossings into one gated event with its mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            event_pulse <= 1'b0;
            event_mask  <= '0;
        end else if (report_en && (cross_vec != '0)) begin
            event_pulse <= 1'b1;
            event_mask  <= cross_vec;
        end else begin
            event_pulse <= 1'b0;
            event_mask  <= '0;
        end
    end
endmodule

// File: rtl/adcwin_checker.sv
// Checker for the ADC window monitor, attached by bind.
module adcwin_checker #(
    parameter int ADC_W   = 10,
    parameter int INTVL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             sample_req,
    input logic             adc_valid,
    input logic             report_en,
    input logic             event_pulse,
    input logic [2:0]       event_mask,
    input logic [3*ADC_W-1:0] snap_data,
    input logic [1:0]       snap_gpio
);
    // R2: a request only follows a cycle carrying a tick.
    p_req_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req |-> $past(tick_en));

    // R7: an event needs reporting enabled on the sampled cycle.
    p_event_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        event_pulse |-> ($past(report_en) && $past(adc_valid)));

    // R8: a pulse always carries at least one crossing channel.
    p_mask_with_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        event_pulse |-> (event_mask != 3'b000));

    // R10: no mask bits without a pulse.
    p_mask_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !event_pulse |-> (event_mask == 3'b000));

    // R3: the snapshot holds when no sample arrived.
    p_snap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(adc_valid) |-> ($stable(snap_data) && $stable(snap_gpio)));
endmodule

bind adc_window_monitor adcwin_checker #(.ADC_W(ADC_W), .INTVL_W(INTVL_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .sample_req  (sample_req),
    .adc_valid   (adc_valid),
    .report_en   (report_en),
    .event_pulse (event_pulse),
    .event_mask  (event_mask),
    .snap_data   (snap_data),
    .snap_gpio   (snap_gpio)
);

// File: tb/test_adc_window_monitor.sv
module test_adc_window_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int ADC_W      = 10;
    localparam int INTVL_W    = 8;
    localparam int DW         = 3 * ADC_W;
    localparam int WD_LIMIT   = 100000;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            tick_en;
    logic [INTVL_W-1:0] intvl;
    logic            sample_req;
    logic            adc_valid;
    logic [DW-1:0]   adc_data;
    logic [1:0]      gpio_lvl;
    logic [DW-1:0]   thr_lo;
    logic [DW-1:0]   thr_hi;
    logic            report_en;
    logic            event_pulse;
    logic [2:0]      event_mask;
    logic [DW-1:0]   snap_data;
    logic [1:0]      snap_gpio;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    string cur_tag = "R1";
    bit    started = 0;

    // Reference model state
    logic          m_req, m_ev;
    logic [2:0]    m_mask;
    logic [DW-1:0] m_snap;
    logic [1:0]    m_gpio;
    bit            m_out [3];
    int            m_ticks;

    adc_window_monitor #(.ADC_W(ADC_W), .INTVL_W(INTVL_W)) i_adc_window_monitor (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .intvl(intvl),
        .sample_req(sample_req), .adc_valid(adc_valid), .adc_data(adc_data),
        .gpio_lvl(gpio_lvl), .thr_lo(thr_lo), .thr_hi(thr_hi),
        .report_en(report_en), .event_pulse(event_pulse), .event_mask(event_mask),
        .snap_data(snap_data), .snap_gpio(snap_gpio)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference model, evaluated at each rising edge.
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_req = 0; m_ev = 0; m_mask = 0; m_snap = 0; m_gpio = 0; m_ticks = 0;
            for (int k = 0; k < 3; k++) m_out[k] = 0;
        end else begin
            int eff;
            logic [2:0] cr;
            eff = (intvl == 0) ? 1 : int'(intvl);
            m_req = 0;
            if (tick_en) begin
                m_ticks++;
                if (m_ticks >= eff) begin
                    m_req = 1;
                    m_ticks = 0;
                end
            end
            m_ev = 0;
            m_mask = 0;
            if (adc_valid) begin
                cr = 0;
                for (int k = 0; k < 3; k++) begin
                    int v, lo, hi;
                    bit o;
                    v  = int'(adc_data[k*ADC_W +: ADC_W]);
                    lo = int'(thr_lo[k*ADC_W +: ADC_W]);
                    hi = int'(thr_hi[k*ADC_W +: ADC_W]);
                    o  = (v < lo) || (v > hi);
                    if (o && !m_out[k]) cr[k] = 1'b1;
                    m_out[k] = o;
                end
                if (report_en && cr != 0) begin
                    m_ev = 1;
                    m_mask = cr;
                end
                m_snap = adc_data;
                m_gpio = gpio_lvl;
            end
        end
    end

    // Compare all outputs against the model away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            chk(cur_tag, "sample_req",  64'(sample_req),  64'(m_req));
            chk(cur_tag, "event_pulse", 64'(event_pulse), 64'(m_ev));
            chk(cur_tag, "event_mask",  64'(event_mask),  64'(m_mask));
            chk(cur_tag, "snap_data",   64'(snap_data),   64'(m_snap));
            chk(cur_tag, "snap_gpio",   64'(snap_gpio),   64'(m_gpio));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d cycles expected<=%0d", cyc, WD_LIMIT);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic sample(logic [ADC_W-1:0] a, logic [ADC_W-1:0] b,
                          logic [ADC_W-1:0] c, logic [1:0] g);
        @(negedge clk);
        adc_data  = {c, b, a};
        gpio_lvl  = g;
        adc_valid = 1'b1;
        @(negedge clk);
        adc_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 0; tick_en = 0; intvl = 8'd10; adc_valid = 0;
        adc_data = '0; gpio_lvl = 2'b00; report_en = 0;
        thr_lo = {10'd100, 10'd100, 10'd100};
        thr_hi = {10'd900, 10'd900, 10'd900};
        idle(3);
        // R1: reset values at the ports
        chk("R1", "reset outputs",
            {31'd0, sample_req, event_pulse, event_mask, snap_gpio},
            64'd0);
        chk("R1", "reset snapshot", 64'(snap_data), 64'd0);
        rst_n = 1;

        // R2: intervals of 3, 0 (acts as 1) and 10 with sparse ticks
        cur_tag = "R2";
        intvl = 8'd3; tick_en = 1; idle(12);
        intvl = 8'd0; idle(5);
        tick_en = 0; intvl = 8'd10; idle(2);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); tick_en = (i % 3 == 0);
        end
        @(negedge clk); tick_en = 0;

        // R9: channel 1 already outside at the first sample; R3 snapshot
        cur_tag = "R9";
        report_en = 1;
        sample(10'd500, 10'd950, 10'd400, 2'b10);
        cur_tag = "R3";
        sample(10'd300, 10'd500, 10'd401, 2'b01);

        // R4: equality with a limit is inside
        cur_tag = "R4";
        sample(10'd100, 10'd900, 10'd900, 2'b11);
        sample(10'd900, 10'd100, 10'd100, 2'b00);

        // R6: no retrigger while outside, fires again after re-entry
        cur_tag = "R6";
        sample(10'd99, 10'd500, 10'd500, 2'b00);
        sample(10'd50, 10'd500, 10'd500, 2'b00);
        sample(10'd500, 10'd500, 10'd500, 2'b00);
        sample(10'd99, 10'd500, 10'd500, 2'b00);
        sample(10'd500, 10'd500, 10'd500, 2'b00);

        // R7: state tracked while reporting is disabled
        cur_tag = "R7";
        report_en = 0;
        sample(10'd500, 10'd500, 10'd901, 2'b01);
        report_en = 1;
        sample(10'd500, 10'd500, 10'd950, 2'b01);
        sample(10'd500, 10'd500, 10'd500, 2'b01);
        sample(10'd500, 10'd500, 10'd901, 2'b01);
        sample(10'd500, 10'd500, 10'd500, 2'b01);

        // R8: all three channels cross together
        cur_tag = "R8";
        sample(10'd0, 10'd1000, 10'd20, 2'b10);
        sample(10'd500, 10'd500, 10'd500, 2'b10);

        // R10: inside samples and back-to-back valids carry no mask
        cur_tag = "R10";
        sample(10'd200, 10'd800, 10'd450, 2'b11);
        @(negedge clk); adc_data = {10'd600, 10'd600, 10'd600}; adc_valid = 1;
        @(negedge clk); adc_data = {10'd700, 10'd700, 10'd700};
        @(negedge clk); adc_valid = 0;

        // R5: random traffic with changing limits and reporting enable
        cur_tag = "R5";
        intvl = 8'd2;
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r1, r2, r3;
            @(negedge clk);
            r1 = $urandom; r2 = $urandom; r3 = $urandom;
            adc_data  = r1[DW-1:0];
            tick_en   = r2[0];
            adc_valid = (r2[2:1] == 2'b00);
            gpio_lvl  = r2[4:3];
            report_en = (r2[6:5] != 2'b00);
            if (r2[10:7] == 4'd0) begin
                thr_lo = {2'b00, r3[7:0], 2'b00, r3[15:8], 2'b00, r3[23:16]};
                thr_hi = {2'b11, r3[15:8], 2'b11, r3[23:16], 2'b11, r3[31:24]};
            end
        end
        @(negedge clk); adc_valid = 0; tick_en = 0;
        idle(3);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule